// File: doc/BRIEF.md
# DMA End-of-Process Qualifier

This block monitors the handshake lines of a DMA channel and decides when a peripheral has signalled the end of a block transfer. The end-of-process line, the DMA acknowledge and one of the read or write strobes are all active low. Together they must stay asserted for a programmable number of consecutive clock cycles before the event counts. Pulses that are shorter, that lack any of the three conditions, or that arrive while DMA mode is off are dropped and leave no trace.

An accepted event sets a sticky end-of-DMA flag. When the end-of-process interrupt enable is set, the same event also raises an interrupt request. Both flags stay set until software pulses the acknowledge strobe or switches DMA mode off. A status byte presents the two flags at fixed bit positions for a register read path.

Top module: `eopq_top`

## Requirements
- R1: After reset, `end_dma`, `irq` and every bit of `status` are 0.
- R2: An overlap is a run of clock cycles in which `eop_n` and `dack_n` are both low and at least one of `rd_n` or `wr_n` is also low. When an overlap lasts at least MIN_CYCLES consecutive cycles, `end_dma` is set. A shorter overlap changes no output.
- R3: If any qualifying input drops for even one cycle, the count of consecutive cycles starts again from zero. Two short overlaps separated by a gap therefore never add up to one long overlap.
- R4: An overlap is accepted only while `dma_mode` is 1. Driving `dma_mode` to 0 clears `end_dma` and `irq` at the next clock edge.
- R5: `irq` is set by an accepted overlap only when `eop_irq_en` is 1. With `eop_irq_en` at 0, `end_dma` is still set and `irq` stays 0.
- R6: The inputs pass through SYNC_STAGES flip-flops. If the inputs are asserted before clock edge 1, `end_dma` is first 1 after edge SYNC_STAGES+MIN_CYCLES and is still 0 after the edge before it.
- R7: `end_dma` and `irq` stay set until a one-cycle `irq_ack` pulse or a low `dma_mode` clears them. Later rejected pulses do not change them.
- R8: Each overlap sets the flags at most once, on its MIN_CYCLES-th cycle. If the flags are cleared while that same overlap continues, they stay clear.
- R9: `status[7]` equals `end_dma` and `status[4]` equals `irq`. All other bits of `status` read as 0.
- R10: If `eop_n` is high, or `dack_n` is high, or `rd_n` and `wr_n` are both high, the remaining lines can stay asserted for any length of time and still change no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eop_n | input | 1 | End-of-process line, active low, asynchronous |
| dack_n | input | 1 | DMA acknowledge, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| dma_mode | input | 1 | DMA mode enable; 0 clears the flags |
| eop_irq_en | input | 1 | End-of-process interrupt enable |
| irq_ack | input | 1 | One-cycle strobe that clears both flags |
| end_dma | output | 1 | Sticky end-of-DMA flag |
| irq | output | 1 | Interrupt request |
| status | output | 8 | Status byte: bit 7 end-of-DMA, bit 4 interrupt active |

## Verification
The bench uses MIN_CYCLES = 3 and SYNC_STAGES = 2. With these values, overlaps of one, two, three and five cycles can be driven in a few cycles each. The accept threshold can be hit exactly, and the output latency of edge 5 can be checked cycle by cycle. The small threshold also makes a gap between two sub-threshold bursts observable, and it lets an acknowledge be placed in the middle of a still-running overlap.

// File: rtl/eopq_pkg.sv
package eopq_pkg;

    localparam int STAT_W       = 8;
    localparam int STAT_END_BIT = 7;
    localparam int STAT_IRQ_BIT = 4;

    // Handshake lines after synchronisation, active high
    typedef struct packed {
        logic eop;
        logic dack;
        logic rd;
        logic wr;
    } hs_t;

    typedef struct packed {
        logic end_dma;
        logic irq;
    } flags_t;

    function automatic logic [STAT_W-1:0] pack_status(flags_t f);
        logic [STAT_W-1:0] s;
        s = '0;
        s[STAT_END_BIT] = f.end_dma;
        s[STAT_IRQ_BIT] = f.irq;
        return s;
    endfunction

endpackage

// File: rtl/eopq_sync.sv
module eopq_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign chain_d[g] = din;
        end else begin : g_next
            assign chain_d[g] = chain_q[g-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= chain_d[i];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/eopq_overlap.sv
module eopq_overlap
    import eopq_pkg::*;
#(
    parameter int MIN_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_mode,
    input  hs_t  hs,
    output logic hit
);

    localparam int CW = $clog2(MIN_CYCLES + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MIN_CYCLES);
    localparam logic [CW-1:0] CNT_LAST = CW'(MIN_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t  st_d, st_q;
    logic qual;

    always_comb begin
        st_d = st_q;
        qual = dma_mode & hs.eop & hs.dack & (hs.rd | hs.wr);
        hit  = qual && (st_q.cnt == CNT_LAST);
        if (!qual) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !qual |=> (st_q.cnt == '0));

    // R8
    single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);

    // R4
    hit_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> dma_mode);

endmodule

// File: rtl/eopq_flags.sv
module eopq_flags
    import eopq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   hit,
    input  logic   dma_mode,
    input  logic   irq_en,
    input  logic   ack,
    output flags_t flags
);

    flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (ack || !dma_mode) begin
            fl_d = '0;
        end
        if (hit) begin
            fl_d.end_dma = 1'b1;
            if (irq_en) fl_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign flags = fl_q;

    // R4
    mode_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_mode |=> (!fl_q.end_dma && !fl_q.irq));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.irq) |-> $past(irq_en));

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_q.end_dma && !ack && dma_mode) |=> fl_q.end_dma);

    // R2
    set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_q.end_dma) |-> $past(hit));

endmodule

// File: rtl/eopq_top.sv
module eopq_top
    import eopq_pkg::*;
#(
    parameter int MIN_CYCLES  = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eop_n,
    input  logic              dack_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              dma_mode,
    input  logic              eop_irq_en,
    input  logic              irq_ack,
    output logic              end_dma,
    output logic              irq,
    output logic [STAT_W-1:0] status
);

    logic [3:0] raw_n, sync_n;
    hs_t        hs;
    logic       hit;
    flags_t     flags;

    assign raw_n = {eop_n, dack_n, rd_n, wr_n};

    eopq_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (4'hF)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_n),
        .dout  (sync_n)
    );

    assign hs = hs_t'(~sync_n);

    eopq_overlap #(
        .MIN_CYCLES (MIN_CYCLES)
    ) u_overlap (
        .clk      (clk),
        .rst_n    (rst_n),
        .dma_mode (dma_mode),
        .hs       (hs),
        .hit      (hit)
    );

    eopq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .dma_mode (dma_mode),
        .irq_en   (eop_irq_en),
        .ack      (irq_ack),
        .flags    (flags)
    );

    assign end_dma = flags.end_dma;
    assign irq     = flags.irq;
    assign status  = pack_status(flags);

    // R9
    status_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[STAT_END_BIT] == end_dma) && (status[STAT_IRQ_BIT] == irq));

    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs.eop || !hs.dack || (!hs.rd && !hs.wr)) |-> !hit);

endmodule

// File: tb/tb_eopq_top.sv
`timescale 1ns/1ps
module tb_eopq_top;

    localparam int MIN_CYCLES  = 3;
    localparam int SYNC_STAGES = 2;
    localparam int NVEC        = 10;

    // {mode, irq_en, rd, wr, dack, eop, hold[3:0], exp_end, exp_irq}
    localparam logic [11:0] VEC [NVEC] = '{
        {6'b111011, 4'd3, 2'b11},   // R2 read, exact threshold
        {6'b101011, 4'd3, 2'b10},   // R5 enable off
        {6'b110111, 4'd5, 2'b11},   // R2 write, long
        {6'b111011, 4'd2, 2'b00},   // R2 too short
        {6'b011011, 4'd6, 2'b00},   // R4 mode off
        {6'b110011, 4'd6, 2'b00},   // R10 no strobe
        {6'b111001, 4'd6, 2'b00},   // R10 no dack
        {6'b111010, 4'd6, 2'b00},   // R10 no eop
        {6'b111111, 4'd3, 2'b11},   // R2 both strobes
        {6'b110111, 4'd1, 2'b00}    // R2 single cycle
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eop_n = 1'b1, dack_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic       dma_mode = 1'b0, eop_irq_en = 1'b0, irq_ack = 1'b0;
    logic       end_dma, irq;
    logic [7:0] status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    eopq_top #(
        .MIN_CYCLES  (MIN_CYCLES),
        .SYNC_STAGES (SYNC_STAGES)
    ) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .eop_n      (eop_n),
        .dack_n     (dack_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .dma_mode   (dma_mode),
        .eop_irq_en (eop_irq_en),
        .irq_ack    (irq_ack),
        .end_dma    (end_dma),
        .irq        (irq),
        .status     (status)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic release_hs();
        eop_n = 1'b1; dack_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic drive_rd(int hold);
        @(negedge clk);
        eop_n = 1'b0; dack_n = 1'b0; rd_n = 1'b0;
        idle(hold);
        release_hs();
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(20.0 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1 reset state
        check("R1 status", status, 8'h00);
        check("R1 flags", {6'b0, end_dma, irq}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        check("R1 after release", status, 8'h00);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            dma_mode   = VEC[v][11];
            eop_irq_en = VEC[v][10];
            ack_pulse();
            @(negedge clk);
            rd_n   = ~VEC[v][9];
            wr_n   = ~VEC[v][8];
            dack_n = ~VEC[v][7];
            eop_n  = ~VEC[v][6];
            idle(int'(VEC[v][5:2]));
            release_hs();
            idle(6);
            check($sformatf("R2 vec%0d end_dma", v), {7'b0, end_dma}, {7'b0, VEC[v][1]});
            check($sformatf("R5 vec%0d irq", v), {7'b0, irq}, {7'b0, VEC[v][0]});
        end

        // R9 status layout, both flags
        dma_mode = 1'b1; eop_irq_en = 1'b1;
        ack_pulse();
        drive_rd(4);
        idle(6);
        check("R9 both set", status, 8'h90);

        // R7 sticky across rejected pulse
        drive_rd(1);
        idle(6);
        check("R7 sticky", status, 8'h90);

        // R7 ack clears
        ack_pulse();
        idle(1);
        check("R7 ack clear", status, 8'h00);

        // R9 end only
        eop_irq_en = 1'b0;
        drive_rd(4);
        idle(6);
        check("R9 end only", status, 8'h80);

        // R4 mode drop clears
        eop_irq_en = 1'b1;
        ack_pulse();
        drive_rd(4);
        idle(6);
        @(negedge clk);
        dma_mode = 1'b0;
        idle(1);
        check("R4 mode clear", status, 8'h00);
        dma_mode = 1'b1;
        idle(2);

        // R6 latency: inputs asserted before edge 1
        @(negedge clk);
        eop_n = 1'b0; dack_n = 1'b0; wr_n = 1'b0;
        idle(SYNC_STAGES + MIN_CYCLES - 1);
        check("R6 not yet", {7'b0, end_dma}, 8'h00);
        idle(1);
        check("R6 on time", {7'b0, end_dma}, 8'h01);

        // R8 ack during the same overlap, flags stay clear
        idle(3);
        ack_pulse();
        idle(4);
        check("R8 no reset in overlap", status, 8'h00);
        release_hs();
        idle(4);

        // R3 two short bursts with a one-cycle gap
        @(negedge clk);
        eop_n = 1'b0; dack_n = 1'b0; rd_n = 1'b0;
        idle(2);
        eop_n = 1'b1;
        idle(1);
        eop_n = 1'b0;
        idle(2);
        release_hs();
        idle(6);
        check("R3 gap restarts", status, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule